// File: doc/BRIEF.md
# Secure GPIO Port Register File

This block is the register file of a single GPIO port with up to 32 pins, reached over a simple word-wide read/write bus. Each access carries a security attribute. The block stores the port output levels and the pin directions. Each of these can be written in full, or changed through a set-only alias or a clear-only alias. The block also keeps one configuration word per pin, which selects direction, input-buffer disconnect, pull, drive mode, sense level and owner. A read-only input register returns the pad levels after a two-flop synchroniser.

A permission vector from the system marks individual pins as secure. A secure access sees and changes every pin. A non-secure access works only on non-secure pins. Bits and configuration words that belong to secure pins read as zero for it, and its writes to them are dropped without any error response. The stored values drive the pad control outputs directly.

Reads are combinational: `rd_data` reflects the addressed register in the same cycle that `bus_sel` is high and `bus_write` is low. Writes take effect on the next rising clock edge.

Top module: `gpio_port_regs`

## Requirements
- R1: After a synchronous active-low reset, the output register and the direction register read 0. Every configuration word reads 0x00000002 (input, buffer disconnected). The input register reads 0.
- R2: A write to the output register (offset 0x004) replaces it. Reads of the output register, its set alias (0x008) and its clear alias (0x00C) all return the output register, and `pin_out` shows it.
- R3: Each 1 written to the set alias (0x008) sets that output bit, and each 1 written to the clear alias (0x00C) clears it. Bits written as 0 keep their value.
- R4: The direction register (0x014) has the same behaviour with its set alias (0x018) and clear alias (0x01C). A 1 means output, and `pin_dir` shows the register.
- R5: Bit 0 of the configuration word for pin n (offset 0x200 + 4n) is the same storage as direction bit n. A change made through either path is visible through the other path and on `pin_dir`.
- R6: The configuration word layout is: bit 0 direction; bit 1 input disconnect; bits 3:2 pull (0 none, 1 down, 3 up); bits 11:8 drive mode; bits 17:16 sense; bits 30:28 owner. All other bits read 0. The fields appear on the pad control outputs.
- R7: A pad level change appears in the input register (0x010) after exactly two rising clock edges.
- R8: The input register reads 0 for every pin whose input buffer is disconnected.
- R9: A non-secure access reads 0 for, and cannot change, the bits of secure pins in the output, direction and input registers and in their aliases.
- R10: A non-secure access to the configuration word of a secure pin reads 0 and its writes are ignored. A non-secure access to the configuration word of a non-secure pin works normally.
- R11: Unmapped offsets read 0 and ignore writes. These include 0x000, 0x020, offsets past the last configuration word, and offsets that are not word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_secure | input | 1 | Access carries the secure attribute |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational, 0 when not reading |
| secure_mask | input | N_PINS | 1 marks a pin as secure |
| pad_in | input | N_PINS | Asynchronous pad levels |
| pin_out | output | N_PINS | Output levels |
| pin_dir | output | N_PINS | Direction, 1 = output |
| pin_in_off | output | N_PINS | Input buffer disconnect |
| pin_pull | output | 2*N_PINS | Pull field per pin |
| pin_drive | output | 4*N_PINS | Drive field per pin |
| pin_sense | output | 2*N_PINS | Sense field per pin |
| pin_owner | output | 3*N_PINS | Owner field per pin |

## Verification
The embedded properties are checked on every cycle:
- set and clear strobes reach the stored output and direction bits;
- a configuration write lands in the shared direction bit;
- a non-secure write never moves a secure pin's state;
- unmapped, locked and reserved read bits stay zero;
- the synchroniser delivers the pad value two edges later.

Some behaviours are shown only by the bench scenarios:
- the full read-back values through each alias;
- the combined effect of mask and input disconnect on the input register;
- the reset image of the configuration words;
- the fact that writes to unmapped offsets leave every register unchanged.

// File: rtl/gpio_port_pkg.sv
// Shared constants and types for the GPIO port register file.
// Assumes a 12-bit byte offset space and word-aligned registers.
package gpio_port_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_OUT    = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_OUTSET = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_OUTCLR = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_IN     = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_DIR    = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_DIRSET = 12'h018;
    localparam logic [ADDR_W-1:0] OFF_DIRCLR = 12'h01C;
    localparam logic [ADDR_W-1:0] OFF_CFG    = 12'h200;

    localparam int PULL_W  = 2;
    localparam int DRIVE_W = 4;
    localparam int SENSE_W = 2;
    localparam int OWNER_W = 3;

    // Bits of a configuration word that hold storage
    localparam logic [DATA_W-1:0] CFG_USED = 32'h7003_0F0F;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_OUT, SEL_OUTSET, SEL_OUTCLR, SEL_IN,
        SEL_DIR, SEL_DIRSET, SEL_DIRCLR, SEL_CFG
    } reg_sel_e;

    // Per-pin configuration apart from the shared direction bit
    typedef struct packed {
        logic [OWNER_W-1:0] owner;
        logic [SENSE_W-1:0] sense;
        logic [DRIVE_W-1:0] drive;
        logic [PULL_W-1:0]  pull;
        logic               in_off;
    } pin_cfg_t;

    // Build the bus image of one configuration word
    function automatic logic [DATA_W-1:0] pack_cfg(pin_cfg_t c, logic dir);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[0]     = dir;
        w[1]     = c.in_off;
        w[3:2]   = c.pull;
        w[11:8]  = c.drive;
        w[17:16] = c.sense;
        w[30:28] = c.owner;
        return w;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
// Address decoder: maps a byte offset to a register selector and a pin index.
// Assumes the configuration base is aligned to a multiple of 4*N_PINS.
module gpio_addr_decode
    import gpio_port_pkg::*;
#(
    parameter int N_PINS = 32,
    localparam int IDX_W = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] CFG_END = ADDR_W'(int'(OFF_CFG) + 4 * N_PINS);

    // Pick the register addressed by the offset
    always_comb begin
        sel = SEL_NONE;
        idx = addr[IDX_W+1:2];
        unique case (addr)
            OFF_OUT:    sel = SEL_OUT;
            OFF_OUTSET: sel = SEL_OUTSET;
            OFF_OUTCLR: sel = SEL_OUTCLR;
            OFF_IN:     sel = SEL_IN;
            OFF_DIR:    sel = SEL_DIR;
            OFF_DIRSET: sel = SEL_DIRSET;
            OFF_DIRCLR: sel = SEL_DIRCLR;
            default: begin
                if (addr >= OFF_CFG && addr < CFG_END && addr[1:0] == 2'b00)
                    sel = SEL_CFG;
            end
        endcase
    end
endmodule

// File: rtl/gpio_in_sync.sv
// Two-flop synchroniser for the asynchronous pad levels.
// Assumes each bit is sampled independently (no bus coherency needed).
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [1:0]   age;

    // Shift pad levels through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    // Count edges since reset so the latency check starts valid
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    // R7: synchronised value is the pad value two edges earlier
    a_r7_two_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_pin_cell.sv
// Storage for one pin: output level, direction and configuration fields.
// Assumes the parent never raises a full-word config write together with
// a set or clear strobe for the same pin.
module gpio_pin_cell
    import gpio_port_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     out_set,
    input  logic     out_clr,
    input  logic     dir_set,
    input  logic     dir_clr,
    input  logic     cfg_we,
    input  pin_cfg_t cfg_wval,
    input  logic     dir_wval,
    output logic     out_q,
    output logic     dir_q,
    output pin_cfg_t cfg_q
);
    localparam pin_cfg_t CFG_RST = '{owner: '0, sense: '0, drive: '0, pull: '0, in_off: 1'b1};

    // Output level register with set priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)       out_q <= 1'b0;
        else if (out_set) out_q <= 1'b1;
        else if (out_clr) out_q <= 1'b0;
    end

    // Direction bit shared by the port register and the config word
    always_ff @(posedge clk) begin
        if (!rst_n)       dir_q <= 1'b0;
        else if (cfg_we)  dir_q <= dir_wval;
        else if (dir_set) dir_q <= 1'b1;
        else if (dir_clr) dir_q <= 1'b0;
    end

    // Remaining configuration fields
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= CFG_RST;
        else if (cfg_we) cfg_q <= cfg_wval;
    end

    // R3: a set strobe leaves the output high
    a_r3_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        out_set |=> out_q);
    // R3: a lone clear strobe leaves the output low
    a_r3_clr_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (out_clr && !out_set) |=> !out_q);
    // R4: direction strobes behave the same way
    a_r4_dir_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_set && !cfg_we) |=> dir_q);
    // R5: a config write lands in the shared direction bit
    a_r5_cfg_dir_shared: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (dir_q == $past(dir_wval)));
endmodule

// File: rtl/gpio_port_regs.sv
// GPIO port register file with per-pin secure masking.
// Assumes combinational reads, single-cycle writes and a stable
// secure_mask during an access; illegal accesses are dropped silently.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int N_PINS = 32,
    localparam int IDX_W = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_write,
    input  logic                    bus_secure,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       rd_data,
    input  logic [N_PINS-1:0]       secure_mask,
    input  logic [N_PINS-1:0]       pad_in,
    output logic [N_PINS-1:0]       pin_out,
    output logic [N_PINS-1:0]       pin_dir,
    output logic [N_PINS-1:0]       pin_in_off,
    output logic [PULL_W*N_PINS-1:0]  pin_pull,
    output logic [DRIVE_W*N_PINS-1:0] pin_drive,
    output logic [SENSE_W*N_PINS-1:0] pin_sense,
    output logic [OWNER_W*N_PINS-1:0] pin_owner
);
    reg_sel_e            sel;
    logic [IDX_W-1:0]    idx;
    logic [N_PINS-1:0]   access_ok;
    logic [N_PINS-1:0]   wbits;
    logic [N_PINS-1:0]   in_sync;
    logic                wr_en;
    logic                rd_en;
    logic [N_PINS-1:0]   out_set, out_clr, dir_set, dir_clr, cfg_we;
    pin_cfg_t            cfg_arr [N_PINS];
    logic [DATA_W-1:0]   cfg_word [N_PINS];
    pin_cfg_t            cfg_wval;
    logic [DATA_W-1:0]   rd_mux;

    gpio_addr_decode #(.N_PINS(N_PINS)) u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .idx  (idx)
    );

    gpio_in_sync #(.W(N_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (in_sync)
    );

    // Bus qualifiers and the per-pin permission for this access
    always_comb begin
        wr_en     = bus_sel && bus_write;
        rd_en     = bus_sel && !bus_write;
        access_ok = bus_secure ? '1 : ~secure_mask;
        wbits     = bus_wdata[N_PINS-1:0] & access_ok;
    end

    // Unpack write data into configuration fields
    always_comb begin
        cfg_wval.in_off = bus_wdata[1];
        cfg_wval.pull   = bus_wdata[3:2];
        cfg_wval.drive  = bus_wdata[11:8];
        cfg_wval.sense  = bus_wdata[17:16];
        cfg_wval.owner  = bus_wdata[30:28];
    end

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        // Per-pin strobes derived from the decoded register and mask
        always_comb begin
            out_set[i] = wr_en && wbits[i] && (sel == SEL_OUT || sel == SEL_OUTSET);
            out_clr[i] = wr_en && access_ok[i] &&
                         ((sel == SEL_OUT && !bus_wdata[i]) || (sel == SEL_OUTCLR && bus_wdata[i]));
            dir_set[i] = wr_en && wbits[i] && (sel == SEL_DIR || sel == SEL_DIRSET);
            dir_clr[i] = wr_en && access_ok[i] &&
                         ((sel == SEL_DIR && !bus_wdata[i]) || (sel == SEL_DIRCLR && bus_wdata[i]));
            cfg_we[i]  = wr_en && sel == SEL_CFG && idx == IDX_W'(i) && access_ok[i];
        end

        gpio_pin_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .out_set  (out_set[i]),
            .out_clr  (out_clr[i]),
            .dir_set  (dir_set[i]),
            .dir_clr  (dir_clr[i]),
            .cfg_we   (cfg_we[i]),
            .cfg_wval (cfg_wval),
            .dir_wval (bus_wdata[0]),
            .out_q    (pin_out[i]),
            .dir_q    (pin_dir[i]),
            .cfg_q    (cfg_arr[i])
        );

        // Fan the stored fields out to the pad control ports
        always_comb begin
            pin_in_off[i]                   = cfg_arr[i].in_off;
            pin_pull[PULL_W*i +: PULL_W]    = cfg_arr[i].pull;
            pin_drive[DRIVE_W*i +: DRIVE_W] = cfg_arr[i].drive;
            pin_sense[SENSE_W*i +: SENSE_W] = cfg_arr[i].sense;
            pin_owner[OWNER_W*i +: OWNER_W] = cfg_arr[i].owner;
            cfg_word[i]                     = pack_cfg(cfg_arr[i], pin_dir[i]);
        end
    end

    // Read multiplexer with per-pin masking
    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_OUT, SEL_OUTSET, SEL_OUTCLR: rd_mux = DATA_W'(pin_out & access_ok);
            SEL_IN:                          rd_mux = DATA_W'(in_sync & ~pin_in_off & access_ok);
            SEL_DIR, SEL_DIRSET, SEL_DIRCLR: rd_mux = DATA_W'(pin_dir & access_ok);
            SEL_CFG:                         rd_mux = access_ok[idx] ? cfg_word[idx] : '0;
            default:                         rd_mux = '0;
        endcase
        rd_data = rd_en ? rd_mux : '0;
    end

    // R9: a non-secure write never moves a secure pin's output or direction
    a_r9_ns_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !bus_secure) |=>
        ((((pin_out ^ $past(pin_out)) | (pin_dir ^ $past(pin_dir))) & $past(secure_mask)) == '0));
    // R9: a non-secure read shows no secure pin bits in the port registers
    a_r9_ns_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !bus_secure && sel != SEL_CFG) |-> ((rd_data[N_PINS-1:0] & secure_mask) == '0));
    // R10: locked configuration words read as zero
    a_r10_cfg_locked_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_CFG && !bus_secure && secure_mask[idx]) |-> (rd_data == '0));
    // R6: reserved configuration bits always read zero
    a_r6_cfg_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_CFG) |-> ((rd_data & ~CFG_USED) == '0));
    // R11: unmapped offsets read zero
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_NONE) |-> (rd_data == '0));
    // R8: disconnected inputs never appear in the input register
    a_r8_in_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_IN) |-> ((rd_data[N_PINS-1:0] & pin_in_off) == '0));
endmodule

// File: tb/sim_gpio_port_regs.sv
// Self-checking bench for gpio_port_regs.
module sim_gpio_port_regs;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_write = 1'b0, bus_secure = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_data;
    logic [N-1:0] secure_mask = 32'hFFFF_0000;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pin_out, pin_dir, pin_in_off;
    logic [2*N-1:0] pin_pull, pin_sense;
    logic [4*N-1:0] pin_drive;
    logic [3*N-1:0] pin_owner;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    gpio_port_regs #(.N_PINS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
        .bus_secure(bus_secure), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_data(rd_data), .secure_mask(secure_mask), .pad_in(pad_in),
        .pin_out(pin_out), .pin_dir(pin_dir), .pin_in_off(pin_in_off),
        .pin_pull(pin_pull), .pin_drive(pin_drive), .pin_sense(pin_sense),
        .pin_owner(pin_owner)
    );

    typedef struct packed {
        logic        wr;
        logic        sec;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 44;
    // Mask is 0xFFFF0000 throughout: pins 16..31 are secure
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b1, 12'h004, 32'hA5A5_A5A5, 32'h0,         8'd2},  // R2
        '{1'b0, 1'b1, 12'h004, 32'h0,         32'hA5A5_A5A5, 8'd2},
        '{1'b0, 1'b0, 12'h004, 32'h0,         32'h0000_A5A5, 8'd9},  // R9
        '{1'b0, 1'b1, 12'h008, 32'h0,         32'hA5A5_A5A5, 8'd2},
        '{1'b0, 1'b1, 12'h00C, 32'h0,         32'hA5A5_A5A5, 8'd2},
        '{1'b1, 1'b1, 12'h008, 32'h0000_000F, 32'h0,         8'd3},  // R3
        '{1'b0, 1'b1, 12'h004, 32'h0,         32'hA5A5_A5AF, 8'd3},
        '{1'b1, 1'b1, 12'h00C, 32'h0000_00F0, 32'h0,         8'd3},
        '{1'b0, 1'b1, 12'h004, 32'h0,         32'hA5A5_A50F, 8'd3},
        '{1'b1, 1'b0, 12'h004, 32'hFFFF_FFFF, 32'h0,         8'd9},
        '{1'b0, 1'b1, 12'h004, 32'h0,         32'hA5A5_FFFF, 8'd9},
        '{1'b1, 1'b0, 12'h00C, 32'hFFFF_FFFF, 32'h0,         8'd9},
        '{1'b0, 1'b1, 12'h004, 32'h0,         32'hA5A5_0000, 8'd9},
        '{1'b1, 1'b1, 12'h014, 32'h0000_FF00, 32'h0,         8'd4},  // R4
        '{1'b0, 1'b1, 12'h014, 32'h0,         32'h0000_FF00, 8'd4},
        '{1'b1, 1'b1, 12'h018, 32'h00FF_0000, 32'h0,         8'd4},
        '{1'b0, 1'b1, 12'h01C, 32'h0,         32'h00FF_FF00, 8'd4},
        '{1'b1, 1'b1, 12'h01C, 32'h0000_0F00, 32'h0,         8'd4},
        '{1'b0, 1'b1, 12'h014, 32'h0,         32'h00FF_F000, 8'd4},
        '{1'b1, 1'b0, 12'h01C, 32'hFFFF_FFFF, 32'h0,         8'd9},
        '{1'b0, 1'b1, 12'h014, 32'h0,         32'h00FF_0000, 8'd9},
        '{1'b0, 1'b1, 12'h240, 32'h0,         32'h0000_0003, 8'd5},  // R5
        '{1'b1, 1'b1, 12'h204, 32'hFFFF_FFFF, 32'h0,         8'd6},  // R6
        '{1'b0, 1'b1, 12'h204, 32'h0,         32'h7003_0F0F, 8'd6},
        '{1'b0, 1'b1, 12'h014, 32'h0,         32'h00FF_0002, 8'd5},
        '{1'b1, 1'b1, 12'h204, 32'h7002_0B0C, 32'h0,         8'd6},
        '{1'b0, 1'b1, 12'h204, 32'h0,         32'h7002_0B0C, 8'd6},
        '{1'b0, 1'b1, 12'h014, 32'h0,         32'h00FF_0000, 8'd5},
        '{1'b1, 1'b0, 12'h240, 32'h0,         32'h0,         8'd10}, // R10
        '{1'b0, 1'b1, 12'h240, 32'h0,         32'h0000_0003, 8'd10},
        '{1'b0, 1'b0, 12'h240, 32'h0,         32'h0,         8'd10},
        '{1'b1, 1'b0, 12'h208, 32'h0000_0001, 32'h0,         8'd10},
        '{1'b0, 1'b0, 12'h208, 32'h0,         32'h0000_0001, 8'd10},
        '{1'b0, 1'b1, 12'h014, 32'h0,         32'h00FF_0004, 8'd5},
        '{1'b1, 1'b1, 12'h020, 32'hFFFF_FFFF, 32'h0,         8'd11}, // R11
        '{1'b0, 1'b1, 12'h020, 32'h0,         32'h0,         8'd11},
        '{1'b1, 1'b1, 12'h000, 32'hFFFF_FFFF, 32'h0,         8'd11},
        '{1'b0, 1'b1, 12'h000, 32'h0,         32'h0,         8'd11},
        '{1'b1, 1'b1, 12'h280, 32'hFFFF_FFFF, 32'h0,         8'd11},
        '{1'b0, 1'b1, 12'h280, 32'h0,         32'h0,         8'd11},
        '{1'b0, 1'b1, 12'h201, 32'h0,         32'h0,         8'd11},
        '{1'b0, 1'b1, 12'h004, 32'h0,         32'hA5A5_0000, 8'd11},
        '{1'b0, 1'b1, 12'h014, 32'h0,         32'h00FF_0004, 8'd11},
        '{1'b0, 1'b0, 12'h014, 32'h0,         32'h0000_0004, 8'd9}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle; reads are sampled just after the driving edge
    task automatic bus(input logic wr, input logic sec, input logic [11:0] addr,
                       input logic [31:0] data, output logic [31:0] rd);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = wr; bus_secure = sec;
        bus_addr = addr; bus_wdata = data;
        #1 rd = rd_data;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_sel = 1'b0; bus_write = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        pad_in = '1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        bus(1'b0, 1'b1, 12'h004, 0, r); check("R1 out", r, 32'h0);
        bus(1'b0, 1'b1, 12'h014, 0, r); check("R1 dir", r, 32'h0);
        bus(1'b0, 1'b1, 12'h27C, 0, r); check("R1 cfg", r, 32'h2);
        bus(1'b0, 1'b1, 12'h010, 0, r); check("R1 in", r, 32'h0);
        pad_in = '0;

        // Vector table walk
        for (int k = 0; k < NV; k++) begin
            bus(TBL[k].wr, TBL[k].sec, TBL[k].addr, TBL[k].data, r);
            if (!TBL[k].wr)
                check($sformatf("R%0d vec %0d", TBL[k].req, k), r, TBL[k].exp);
        end
        idle();
        // R2 / R6: pad control outputs
        check("R2 pin_out", pin_out, 32'hA5A5_0000);
        check("R6 drive pin1", 32'(pin_drive[7:4]), 32'hB);
        check("R6 pull pin1", 32'(pin_pull[3:2]), 32'h3);
        check("R6 sense pin1", 32'(pin_sense[3:2]), 32'h2);
        check("R6 owner pin1", 32'(pin_owner[5:3]), 32'h7);

        // Connect pins 0 and 20 as inputs (pins 1 and 2 already connected)
        bus(1'b1, 1'b1, 12'h200, 32'h0, r);
        bus(1'b1, 1'b1, 12'h250, 32'h0, r);
        idle();
        check("R5 pin_dir", pin_dir, 32'h00EF_0004);

        // R7: two-edge latency, R8: disconnected pins read zero
        @(negedge clk) pad_in = '1;
        bus(1'b0, 1'b1, 12'h010, 0, r); check("R7 one edge", r, 32'h0);
        bus(1'b0, 1'b1, 12'h010, 0, r); check("R8 in secure", r, 32'h0010_0007);
        bus(1'b0, 1'b0, 12'h010, 0, r); check("R9 in nonsecure", r, 32'h0000_0007);
        @(negedge clk) pad_in = '0;
        bus(1'b0, 1'b1, 12'h010, 0, r); check("R7 fall one edge", r, 32'h0010_0007);
        bus(1'b0, 1'b1, 12'h010, 0, r); check("R7 fall two edges", r, 32'h0);

        // R1: reset again from a busy state
        pad_in = '1;
        idle();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        bus(1'b0, 1'b1, 12'h004, 0, r); check("R1 out again", r, 32'h0);
        bus(1'b0, 1'b1, 12'h014, 0, r); check("R1 dir again", r, 32'h0);
        bus(1'b0, 1'b1, 12'h204, 0, r); check("R1 cfg again", r, 32'h2);
        bus(1'b0, 1'b1, 12'h010, 0, r); check("R1 in again", r, 32'h0);
        idle();

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule